// File: doc/BRIEF.md
# Loop Execution Profiling Table

This block counts, in hardware, how often each candidate loop of a small embedded processor is entered, and then names the busiest one. A two-bit phase input steers it through three steps. In the seeding phase, a scan port hands it loop start addresses that an external walker found in the program image, and each new address takes the next empty slot of a small table with its count at zero. In the profiling phase, a fetch-trace port presents the address of every executed instruction. All slots compare against it in parallel, and the matching slot's counter advances by one in that cycle. In the configuration phase, the block picks the slot with the largest count. It then issues one write to a configuration store, carrying that loop address and a valid flag, and pulses a done output.

Outside the three phases the block is inert and leaves normal execution untouched. Loop detection, the processor core and the program memory are outside this block.

Top module: `loop_heat_table`

## Requirements
- R1: After reset no configuration write and no done pulse is issued, and the table is empty, so a configuration run straight after reset writes a valid flag of 0.
- R2: Phase encoding is 00 idle, 01 seed, 10 profile, 11 configure. The clock edge on which the phase first reads 01 (coming from any other phase) empties the table. While the phase is 01, each edge with `seed_valid_i` high places `seed_addr_i` into the lowest empty slot with a count of zero.
- R3: A seed address already present in the table does not take a second slot.
- R4: Seed addresses offered while every slot is full are dropped.
- R5: In phase 10, each edge with `trace_valid_i` high adds one to the count of the slot whose address equals `trace_addr_i`. Back-to-back trace cycles each count.
- R6: A trace address that matches no slot changes no count.
- R7: A count that reaches its all-ones value stays there and does not wrap.
- R8: On the first edge with phase 11, the block latches the result. In the next cycle `cfg_wr_o` is high for exactly one cycle, with `cfg_loop_o` holding the address of the highest count and `cfg_ok_o` high.
- R9: When several slots share the highest count, the slot with the lowest index wins.
- R10: When every count is zero, the write carries `cfg_ok_o` = 0 and `cfg_loop_o` = 0.
- R11: `done_o` is high for one cycle, in the cycle after the write. No further write occurs until the phase has left 11 and entered it again.
- R12: In phase 00, seed and trace inputs change nothing in the table, and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Phase select: 00 idle, 01 seed, 10 profile, 11 configure |
| seed_valid_i | input | 1 | Scan port strobe carrying a candidate loop address |
| seed_addr_i | input | ADDR_W | Candidate loop start address |
| trace_valid_i | input | 1 | Fetch-trace strobe |
| trace_addr_i | input | ADDR_W | Address of the instruction executed this cycle |
| cfg_wr_o | output | 1 | One-cycle write strobe to the configuration store |
| cfg_loop_o | output | ADDR_W | Chosen loop address (0 when none) |
| cfg_ok_o | output | 1 | Valid flag written with the address |
| done_o | output | 1 | One-cycle pulse after the configuration write |

## Verification
The bench builds the table with four slots, 16-bit addresses and 4-bit counters. With four slots, a fifth distinct seed and a repeated seed both fall within a few cycles of stimulus. With 4-bit counters, a count saturates at 15 after fifteen trace hits, so twenty hits on one slot against fifteen on a later slot show whether the counter stuck or wrapped. Ties between a saturated slot and a later slot at the same ceiling then exercise the lower-index rule at its limit.

// File: rtl/loop_heat_pkg.sv
// Shared types for the loop profiling table.
// Assumes: phase codes are fixed by the top-level encoding in the brief.
package loop_heat_pkg;

    // Phase selected by the two-bit mode input
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_SEED = 2'b01,
        PH_PROF = 2'b10,
        PH_CONF = 2'b11
    } phase_e;

    // Configuration-write sequencer states
    typedef enum logic [1:0] {
        CS_IDLE  = 2'b00,
        CS_WRITE = 2'b01,
        CS_DONE  = 2'b10,
        CS_HOLD  = 2'b11
    } cfg_state_e;

endpackage

// File: rtl/loop_heat_cam.sv
// Fully associative address-to-count store.
// Every slot compares its address with the seed and trace addresses in parallel.
// A new seed takes the lowest empty slot unless it is already present or the
// table is full. A trace hit advances the matching slot's saturating counter.
// Assumes: clear_i, seed_en_i and hit_en_i come from mutually exclusive phases,
// except clear_i and seed_en_i, which may share a cycle (clear applies first).
module loop_heat_cam #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear_i,
    input  logic                              seed_en_i,
    input  logic [ADDR_W-1:0]                 seed_addr_i,
    input  logic                              hit_en_i,
    input  logic [ADDR_W-1:0]                 hit_addr_i,
    output logic [ENTRIES-1:0]                ent_vld_o,
    output logic [ENTRIES-1:0][ADDR_W-1:0]    ent_addr_o,
    output logic [ENTRIES-1:0][COUNT_W-1:0]   ent_cnt_o
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

    logic                vld_q  [ENTRIES];
    logic [ADDR_W-1:0]   addr_q [ENTRIES];
    logic [COUNT_W-1:0]  cnt_q  [ENTRIES];

    logic [ENTRIES-1:0]  live;
    logic [ENTRIES-1:0]  seed_match;
    logic [ENTRIES-1:0]  hit_match;
    logic                free_found;
    logic [IDX_W-1:0]    free_idx;
    logic                alloc;

    // Occupancy seen by this cycle's seed, after a same-cycle clear
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            live[i]       = clear_i ? 1'b0 : vld_q[i];
            seed_match[i] = live[i] && (addr_q[i] == seed_addr_i);
            hit_match[i]  = vld_q[i] && (addr_q[i] == hit_addr_i);
        end
    end

    // Lowest-index empty slot, scanned downward so the smallest index is kept
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!live[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // A seed allocates only when it is new and room remains
    assign alloc = seed_en_i && !(|seed_match) && free_found;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            // Per-slot state: clear, allocate, or count a trace hit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[g]  <= 1'b0;
                    addr_q[g] <= '0;
                    cnt_q[g]  <= '0;
                end else begin
                    if (clear_i) begin
                        vld_q[g] <= 1'b0;
                    end
                    if (alloc && (free_idx == IDX_W'(g))) begin
                        vld_q[g]  <= 1'b1;
                        addr_q[g] <= seed_addr_i;
                        cnt_q[g]  <= '0;
                    end else if (hit_en_i && hit_match[g] && (cnt_q[g] != CNT_MAX)) begin
                        cnt_q[g] <= cnt_q[g] + 1'b1;
                    end
                end
            end

            assign ent_vld_o[g]  = vld_q[g];
            assign ent_addr_o[g] = addr_q[g];
            assign ent_cnt_o[g]  = cnt_q[g];
        end
    endgenerate

endmodule

// File: rtl/loop_heat_pick.sv
// Combinational selection of the busiest slot.
// A linear chain keeps a running best. A slot replaces it only with a strictly
// larger count, so equal counts keep the lower index and zero counts never win.
// Assumes: empty slots are masked by ent_vld_i.
module loop_heat_pick #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 16
) (
    input  logic [ENTRIES-1:0]                ent_vld_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]    ent_addr_i,
    input  logic [ENTRIES-1:0][COUNT_W-1:0]   ent_cnt_i,
    output logic [ADDR_W-1:0]                 best_addr_o,
    output logic                              best_ok_o
);

    logic [COUNT_W-1:0] run_cnt  [ENTRIES+1];
    logic [ADDR_W-1:0]  run_addr [ENTRIES+1];

    assign run_cnt[0]  = '0;
    assign run_addr[0] = '0;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_stage
            logic take;
            // Stage g: replace the running best only on a strictly larger count
            assign take = ent_vld_i[g] && (ent_cnt_i[g] > run_cnt[g]);
            assign run_cnt[g+1]  = take ? ent_cnt_i[g]  : run_cnt[g];
            assign run_addr[g+1] = take ? ent_addr_i[g] : run_addr[g];
        end
    endgenerate

    assign best_addr_o = run_addr[ENTRIES];
    assign best_ok_o   = (run_cnt[ENTRIES] != '0);

endmodule

// File: rtl/loop_heat_seq.sv
// Phase decoder and configuration-write sequencer.
// It turns the mode input into table enables and detects entry into the seed
// phase. On entry into the configure phase it latches the picked result,
// writes once, pulses done, then waits for the phase to leave configure.
// Assumes: the mode input is synchronous to clk.
module loop_heat_seq
    import loop_heat_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              seed_valid_i,
    input  logic              trace_valid_i,
    input  logic [ADDR_W-1:0] best_addr_i,
    input  logic              best_ok_i,
    output logic              clear_o,
    output logic              seed_en_o,
    output logic              hit_en_o,
    output logic              cfg_wr_o,
    output logic [ADDR_W-1:0] cfg_loop_o,
    output logic              cfg_ok_o,
    output logic              done_o
);

    phase_e             phase;
    phase_e             phase_prev;
    cfg_state_e         st;
    logic [ADDR_W-1:0]  loop_q;
    logic               ok_q;

    assign phase = phase_e'(mode_i);

    // Remember last cycle's phase to detect entry into seeding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_prev <= PH_IDLE;
        end else begin
            phase_prev <= phase;
        end
    end

    // Table enables decoded from the current phase
    always_comb begin
        clear_o   = (phase == PH_SEED) && (phase_prev != PH_SEED);
        seed_en_o = (phase == PH_SEED) && seed_valid_i;
        hit_en_o  = (phase == PH_PROF) && trace_valid_i;
    end

    // Configure sequencer: latch result, write, signal done, hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= CS_IDLE;
            loop_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            case (st)
                CS_IDLE: begin
                    if (phase == PH_CONF) begin
                        st     <= CS_WRITE;
                        loop_q <= best_addr_i;
                        ok_q   <= best_ok_i;
                    end
                end
                CS_WRITE: st <= CS_DONE;
                CS_DONE:  st <= CS_HOLD;
                CS_HOLD: begin
                    if (phase != PH_CONF) begin
                        st <= CS_IDLE;
                    end
                end
                default:  st <= CS_IDLE;
            endcase
        end
    end

    assign cfg_wr_o   = (st == CS_WRITE);
    assign done_o     = (st == CS_DONE);
    assign cfg_loop_o = loop_q;
    assign cfg_ok_o   = ok_q;

endmodule

// File: rtl/loop_heat_table.sv
// Loop execution profiling table, top level.
// It joins the associative store, the busiest-slot picker and the phase
// sequencer.
// Assumes: all inputs are synchronous to clk, and an external walker supplies
// the seed addresses.
module loop_heat_table #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              seed_valid_i,
    input  logic [ADDR_W-1:0] seed_addr_i,
    input  logic              trace_valid_i,
    input  logic [ADDR_W-1:0] trace_addr_i,
    output logic              cfg_wr_o,
    output logic [ADDR_W-1:0] cfg_loop_o,
    output logic              cfg_ok_o,
    output logic              done_o
);

    logic                              clear;
    logic                              seed_en;
    logic                              hit_en;
    logic [ENTRIES-1:0]                ent_vld;
    logic [ENTRIES-1:0][ADDR_W-1:0]    ent_addr;
    logic [ENTRIES-1:0][COUNT_W-1:0]   ent_cnt;
    logic [ADDR_W-1:0]                 best_addr;
    logic                              best_ok;

    loop_heat_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .seed_valid_i  (seed_valid_i),
        .trace_valid_i (trace_valid_i),
        .best_addr_i   (best_addr),
        .best_ok_i     (best_ok),
        .clear_o       (clear),
        .seed_en_o     (seed_en),
        .hit_en_o      (hit_en),
        .cfg_wr_o      (cfg_wr_o),
        .cfg_loop_o    (cfg_loop_o),
        .cfg_ok_o      (cfg_ok_o),
        .done_o        (done_o)
    );

    loop_heat_cam #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .COUNT_W (COUNT_W)
    ) u_cam (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .seed_en_i   (seed_en),
        .seed_addr_i (seed_addr_i),
        .hit_en_i    (hit_en),
        .hit_addr_i  (trace_addr_i),
        .ent_vld_o   (ent_vld),
        .ent_addr_o  (ent_addr),
        .ent_cnt_o   (ent_cnt)
    );

    loop_heat_pick #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .COUNT_W (COUNT_W)
    ) u_pick (
        .ent_vld_i   (ent_vld),
        .ent_addr_i  (ent_addr),
        .ent_cnt_i   (ent_cnt),
        .best_addr_o (best_addr),
        .best_ok_o   (best_ok)
    );

endmodule

// File: rtl/loop_heat_chk.sv
// Temporal checks on the profiling table's configuration interface.
// Assumes: bound to loop_heat_table; observes ports only.
module loop_heat_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              cfg_wr_o,
    input logic [ADDR_W-1:0] cfg_loop_o,
    input logic              cfg_ok_o,
    input logic              done_o
);

    // R1: a reset cycle leaves no write and no done pending
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!cfg_wr_o && !done_o));

    // R12: a write only follows a cycle spent in the configure phase
    assert_write_needs_conf_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> ($past(mode_i) == 2'b11));

    // R10: an invalid result carries a zero address
    assert_empty_pick_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_o && !cfg_ok_o) |-> (cfg_loop_o == '0));

    // R11: done follows the write in the next cycle and the write does not repeat
    assert_done_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |=> (done_o && !cfg_wr_o));

    // R11: done is a single-cycle pulse with no write behind it
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !cfg_wr_o));

    // R8: the written address and flag stay steady across the done cycle
    assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($stable(cfg_loop_o) && $stable(cfg_ok_o)));

endmodule

bind loop_heat_table loop_heat_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .cfg_wr_o   (cfg_wr_o),
    .cfg_loop_o (cfg_loop_o),
    .cfg_ok_o   (cfg_ok_o),
    .done_o     (done_o)
);

// File: tb/loop_heat_table_bench.sv
`timescale 1ns/1ps
module loop_heat_table_bench;

    localparam int ENTRIES = 4;
    localparam int ADDR_W  = 16;
    localparam int COUNT_W = 4;

    typedef struct packed {
        logic [3:0][15:0] addr;
        logic [3:0][7:0]  hits;
        logic [15:0]      exp_addr;
        logic             exp_ok;
    } vec_t;

    // Slot fields are listed {slot3, slot2, slot1, slot0}
    localparam int N_VEC = 6;
    localparam vec_t VECS [N_VEC] = '{
        // R5 R8: plain maximum
        '{ {16'h0400, 16'h0300, 16'h0200, 16'h0100}, {8'd5, 8'd2, 8'd7, 8'd3},  16'h0200, 1'b1 },
        // R2 R10: same seeds again, table must have been emptied
        '{ {16'h0400, 16'h0300, 16'h0200, 16'h0100}, {8'd0, 8'd0, 8'd0, 8'd0},  16'h0000, 1'b0 },
        // R9: tie keeps the lower slot
        '{ {16'h0D40, 16'h0C30, 16'h0B20, 16'h0A10}, {8'd0, 8'd1, 8'd4, 8'd4},  16'h0A10, 1'b1 },
        // R7: 20 hits saturate at 15 and tie with 15
        '{ {16'h4000, 16'h3000, 16'h2000, 16'h1000}, {8'd0, 8'd0, 8'd15, 8'd20}, 16'h1000, 1'b1 },
        // R8: only the last slot counts
        '{ {16'h0400, 16'h0300, 16'h0200, 16'h0100}, {8'd1, 8'd0, 8'd0, 8'd0},  16'h0400, 1'b1 },
        // R7 R9: two slots at the ceiling
        '{ {16'h8000, 16'h7000, 16'h6000, 16'h5000}, {8'd15, 8'd2, 8'd0, 8'd15}, 16'h5000, 1'b1 }
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic              seed_valid = 1'b0;
    logic [ADDR_W-1:0] seed_addr = '0;
    logic              trace_valid = 1'b0;
    logic [ADDR_W-1:0] trace_addr = '0;
    logic              cfg_wr;
    logic [ADDR_W-1:0] cfg_loop;
    logic              cfg_ok;
    logic              done;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    loop_heat_table #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .COUNT_W (COUNT_W)
    ) u_loop_heat_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .seed_valid_i  (seed_valid),
        .seed_addr_i   (seed_addr),
        .trace_valid_i (trace_valid),
        .trace_addr_i  (trace_addr),
        .cfg_wr_o      (cfg_wr),
        .cfg_loop_o    (cfg_loop),
        .cfg_ok_o      (cfg_ok),
        .done_o        (done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        mode = 2'b00; seed_valid = 1'b0; trace_valid = 1'b0;
    endtask

    task automatic seed_one(input logic [15:0] a);
        @(negedge clk);
        mode = 2'b01; trace_valid = 1'b0; seed_valid = 1'b1; seed_addr = a;
    endtask

    task automatic hit_one(input logic [15:0] a);
        @(negedge clk);
        mode = 2'b10; seed_valid = 1'b0; trace_valid = 1'b1; trace_addr = a;
    endtask

    // Enter configure, then check the write, the done pulse and the quiet hold
    task automatic run_conf(input string req, input logic [15:0] ea, input logic eo);
        @(negedge clk);
        mode = 2'b11; seed_valid = 1'b0; trace_valid = 1'b0;
        @(negedge clk);
        chk({req, " R8 write strobe"}, 32'(cfg_wr), 32'd1);
        chk({req, " address"}, 32'(cfg_loop), 32'(ea));
        chk({req, " valid flag"}, 32'(cfg_ok), 32'(eo));
        chk({req, " R11 no early done"}, 32'(done), 32'd0);
        @(negedge clk);
        chk({req, " R11 done pulse"}, 32'(done), 32'd1);
        chk({req, " R11 single write"}, 32'(cfg_wr), 32'd0);
        @(negedge clk);
        chk({req, " R11 done ends"}, 32'({done, cfg_wr}), 32'd0);
        mode = 2'b00;
    endtask

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset, and an empty table yields flag 0
        chk("R1 no write after reset", 32'(cfg_wr), 32'd0);
        chk("R1 no done after reset", 32'(done), 32'd0);
        run_conf("R1 empty table", 16'h0000, 1'b0);

        // Vector table walk
        for (int v = 0; v < N_VEC; v++) begin
            idle_cycle();
            for (int e = 0; e < 4; e++) seed_one(VECS[v].addr[e]);
            for (int e = 0; e < 4; e++) begin
                for (int h = 0; h < int'(VECS[v].hits[e]); h++) hit_one(VECS[v].addr[e]);
            end
            run_conf($sformatf("vector %0d", v), VECS[v].exp_addr, VECS[v].exp_ok);
        end

        // R3: a repeated seed must not take a slot, so 0x0040 still fits
        idle_cycle();
        seed_one(16'h0010); seed_one(16'h0010); seed_one(16'h0020);
        seed_one(16'h0030); seed_one(16'h0040);
        repeat (3) hit_one(16'h0040);
        run_conf("R3 duplicate seed", 16'h0040, 1'b1);

        // R4: a fifth distinct seed is dropped
        idle_cycle();
        seed_one(16'h0011); seed_one(16'h0022); seed_one(16'h0033);
        seed_one(16'h0044); seed_one(16'h0055);
        repeat (5) hit_one(16'h0055);
        hit_one(16'h0011);
        run_conf("R4 capacity", 16'h0011, 1'b1);

        // R6: unmatched trace addresses count nowhere
        idle_cycle();
        seed_one(16'h0011); seed_one(16'h0022); seed_one(16'h0033); seed_one(16'h0044);
        repeat (6) hit_one(16'h0099);
        repeat (2) hit_one(16'h0033);
        run_conf("R6 unmatched trace", 16'h0033, 1'b1);

        // R12: idle-phase traffic changes nothing and writes nothing
        idle_cycle();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            mode = 2'b00; trace_valid = 1'b1; trace_addr = 16'h0044;
            seed_valid = 1'b1; seed_addr = 16'h0077;
        end
        @(negedge clk);
        chk("R12 no write in idle", 32'({cfg_wr, done}), 32'd0);
        seed_valid = 1'b0; trace_valid = 1'b0;
        run_conf("R12 idle ignored", 16'h0033, 1'b1);

        idle_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule